// File: doc/BRIEF.md
# Dithered PWM with Shutdown

This block drives a complementary pair of PWM outputs from a free-running counter. Its average duty cycle is finer than one counter step. A duty word holds an integer count and a fractional step in 1/32 units. Over a frame of 32 periods, the block uses the next-larger integer count in exactly as many periods as the step says. Those periods are spread across the frame by a bit-reversed period index, so the averaged output ripples as little as possible.

Software reaches the block through a byte-wide write/read port. The duty word is split over two byte addresses. A high-byte write waits in a holding register until the low byte arrives, and then the whole word commits at once. Four control bits set the following:
- run enable
- duty mode versus frequency mode
- drive of the output pins
- whether an active-low kill input is honoured

When the kill input is honoured and goes low, both outputs drop at once and the run enable clears itself.

Top module: `dither_pwm`

## Requirements
- R1: After reset both outputs are 0 and every readable register (addresses 0, 1, 2) reads 0.
- R2: Address 0 holds control bits: bit 0 run enable, bit 1 duty mode (1 = variable duty, 0 = variable frequency), bit 2 output drive, bit 3 kill honour. Address 1 holds the duty word bits above bit 7, and address 2 holds bits 7:0. The duty word is {DC, STEP}, with STEP in bits 4:0 and DC above it. Reads return the committed word.
- R3: A write to address 1 alters neither the readback nor the outputs. The word commits, with both bytes, in the cycle after the write to address 2.
- R4: While run enable and duty mode are both 1, a counter of 2^CNT_W clocks per period runs. It reads 0 in the cycle after the enabling write. pwm_p is 1 while the count is below the duty applied to that period.
- R5: In period p of a frame, the applied duty is DC+1 when the 5-bit reversal of (p mod 32) is below STEP, and DC otherwise. One 32-period frame therefore gives 32*DC+STEP high clocks.
- R6: While the block is active, pwm_n is the complement of pwm_p. The two are never 1 together.
- R7: A newly committed duty word is applied from the next period start onward. The running period keeps its old duty.
- R8: With run enable 0, both outputs are 0.
- R9: With output drive 0, both outputs are 0.
- R10: In frequency mode (bit 1 = 0), both outputs are 0 whatever the duty word holds.
- R11: With kill honour 1, a low kill_n forces both outputs to 0 in the same cycle. Run enable then reads 0 after at most three clock edges.
- R12: While a honoured kill is held low, a write that sets run enable is overridden and reads back 0. Once kill_n has been high across two edges, the write takes effect.
- R13: With kill honour 0, kill_n has no effect on the outputs or on run enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| kill_n | input | 1 | Active-low shutdown request |
| pwm_p | output | 1 | Primary PWM output |
| pwm_n | output | 1 | Complementary PWM output |

## Verification
Register writes land on the clock edge that samples the strobe, so readback and output state reflect them in the next cycle. The counter reads 0 in that cycle. Each output expectation is tagged with the exact cycle number measured from the enabling write, and the monitor compares it in that cycle's low phase. Kill gating is combinational and is checked a moment after kill_n moves. The enable clear passes through a two-stage synchronizer, so it is read back three edges later. The re-enable write is issued only after kill_n has been high across two edges.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;

  typedef struct packed {
    logic sd_en;      // bit 3: honour kill_n
    logic out_en;     // bit 2: drive pins
    logic duty_mode;  // bit 1: 1 = variable duty, 0 = variable frequency
    logic run_en;     // bit 0: run
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
  localparam logic [1:0] ADDR_DUTY_LO = 2'd2;

endpackage

// File: rtl/dpwm_rstsync.sv
module dpwm_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dpwm_regs.sv
// Register file: control, duty holding byte, committed duty word and
// the kill synchronizer that clears the run bit. Requires 9..16 duty bits.
module dpwm_regs
  import dither_pwm_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [1:0]                rd_addr,
  input  logic                      kill_n,
  output logic [7:0]                rd_data,
  output ctrl_t                     ctrl,
  output logic [CNT_W+STEP_W-1:0]   duty_act
);
  localparam int DUTY_W = CNT_W + STEP_W;
  localparam int HI_W   = DUTY_W - 8;

  logic [1:0]        ksync_q, ksync_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ctrl_ce;
  logic [HI_W-1:0]   hold_q, hold_d;
  logic              hold_ce;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              act_ce;
  logic              wr_ctrl, wr_hi, wr_lo, kill_hold;
  logic [7:0]        rd_hi;

  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    wr_hi     = wr_en && (wr_addr == ADDR_DUTY_HI);
    wr_lo     = wr_en && (wr_addr == ADDR_DUTY_LO);
    kill_hold = ctrl_q.sd_en && !ksync_q[1];
    ksync_d   = {ksync_q[0], kill_n};

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = ctrl_t'(wr_data[3:0]);
    end
    if (kill_hold) begin
      ctrl_d.run_en = 1'b0;   // shutdown wins over a same-cycle write
    end
    ctrl_ce = wr_ctrl || kill_hold;

    hold_d  = wr_data[HI_W-1:0];
    hold_ce = wr_hi;

    act_d  = {hold_q, wr_data};
    act_ce = wr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ksync_q <= 2'b11;
      ctrl_q  <= '0;
      hold_q  <= '0;
      act_q   <= '0;
    end else begin
      ksync_q <= ksync_d;
      if (ctrl_ce) begin
        ctrl_q <= ctrl_d;
      end
      if (hold_ce) begin
        hold_q <= hold_d;
      end
      if (act_ce) begin
        act_q <= act_d;
      end
    end
  end

  always_comb begin
    rd_hi = '0;
    rd_hi[HI_W-1:0] = act_q[DUTY_W-1:8];
    case (rd_addr)
      ADDR_CTRL:    rd_data = {4'b0000, ctrl_q};
      ADDR_DUTY_HI: rd_data = rd_hi;
      ADDR_DUTY_LO: rd_data = act_q[7:0];
      default:      rd_data = 8'h00;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign duty_act = act_q;
endmodule

// File: rtl/dpwm_core.sv
// Period counter, frame index and per-period applied duty.
module dpwm_core #(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [CNT_W+STEP_W-1:0] duty,
  output logic                    raw_p,
  output logic [CNT_W-1:0]        cnt,
  output logic [STEP_W-1:0]       frame,
  output logic [CNT_W:0]          eff
);
  localparam int DUTY_W = CNT_W + STEP_W;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] frm_q, frm_d;
  logic              frm_ce;
  logic [CNT_W:0]    eff_q, eff_d;
  logic              eff_ce;
  logic              wrap, bonus;
  logic [STEP_W-1:0] fidx_ld, fidx_rev;
  logic [CNT_W-1:0]  dc_field;
  logic [STEP_W-1:0] step_field;

  // bit reversal spreads the enlarged periods evenly across the frame
  for (genvar i = 0; i < STEP_W; i++) begin : g_rev
    assign fidx_rev[i] = fidx_ld[STEP_W-1-i];
  end

  always_comb begin
    dc_field   = duty[DUTY_W-1:STEP_W];
    step_field = duty[STEP_W-1:0];
    wrap       = run && (cnt_q == CNT_LAST);

    cnt_d   = run ? (cnt_q + 1'b1) : '0;
    fidx_ld = run ? (frm_q + 1'b1) : '0;
    frm_d   = fidx_ld;
    frm_ce  = wrap || !run;

    bonus  = (fidx_rev < step_field);
    eff_d  = {1'b0, dc_field} + {{CNT_W{1'b0}}, bonus};
    eff_ce = wrap || !run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      frm_q <= '0;
      eff_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (frm_ce) begin
        frm_q <= frm_d;
      end
      if (eff_ce) begin
        eff_q <= eff_d;
      end
    end
  end

  assign raw_p = ({1'b0, cnt_q} < eff_q);
  assign cnt   = cnt_q;
  assign frame = frm_q;
  assign eff   = eff_q;
endmodule

// File: rtl/dpwm_gate.sv
// Output gating: enables, mode and the immediate kill path.
module dpwm_gate
  import dither_pwm_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  kill_n,
  input  logic  raw_p,
  output logic  pwm_p,
  output logic  pwm_n
);
  logic active;

  always_comb begin
    active = ctrl.run_en && ctrl.duty_mode && ctrl.out_en
             && !(ctrl.sd_en && !kill_n);
    pwm_p  = active && raw_p;
    pwm_n  = active && !raw_p;
  end
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dither_pwm_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       kill_n,
  output logic       pwm_p,
  output logic       pwm_n
);
  localparam int DUTY_W = CNT_W + STEP_W;

  logic              rst_s;
  ctrl_t             ctrl_w;
  logic [DUTY_W-1:0] duty_w;
  logic              run_w, raw_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [STEP_W-1:0] frame_w;
  logic [CNT_W:0]    eff_w;

  dpwm_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  dpwm_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .kill_n   (kill_n),
    .rd_data  (rd_data),
    .ctrl     (ctrl_w),
    .duty_act (duty_w)
  );

  assign run_w = ctrl_w.run_en && ctrl_w.duty_mode;

  dpwm_core #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_core (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (run_w),
    .duty  (duty_w),
    .raw_p (raw_w),
    .cnt   (cnt_w),
    .frame (frame_w),
    .eff   (eff_w)
  );

  dpwm_gate u_gate (
    .ctrl   (ctrl_w),
    .kill_n (kill_n),
    .raw_p  (raw_w),
    .pwm_p  (pwm_p),
    .pwm_n  (pwm_n)
  );
endmodule

// File: rtl/dither_pwm_checker.sv
module dither_pwm_checker
  import dither_pwm_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int STEP_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_addr,
  input logic                    kill_n,
  input logic [3:0]              ctrl,
  input logic [CNT_W+STEP_W-1:0] duty_act,
  input logic [CNT_W-1:0]        cnt,
  input logic [STEP_W-1:0]       frame,
  input logic [CNT_W:0]          eff,
  input logic                    pwm_p,
  input logic                    pwm_n
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;
  logic run;
  assign run = ctrl[0] && ctrl[1];

  assert_rails_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_p && pwm_n));

  assert_off_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> (!pwm_p && !pwm_n));

  assert_off_without_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> (!pwm_p && !pwm_n));

  assert_quiet_in_freq_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |-> (!pwm_p && !pwm_n));

  assert_kill_forces_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && !kill_n) |-> (!pwm_p && !pwm_n));

  assert_kill_clears_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3] && ($past(kill_n, 2) == 1'b0)) |=> !ctrl[0]);

  assert_hi_byte_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == ADDR_DUTY_LO)) |=> $stable(duty_act));

  assert_duty_fixed_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt != CNT_LAST)) |=> $stable(eff));

  assert_frame_steps_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt != CNT_LAST)) |=> $stable(frame));

  assert_counter_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

bind dither_pwm dither_pwm_checker #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_check (
  .clk      (clk),
  .rst_n    (rst_s),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .kill_n   (kill_n),
  .ctrl     (ctrl_w),
  .duty_act (duty_w),
  .cnt      (cnt_w),
  .frame    (frame_w),
  .eff      (eff_w),
  .pwm_p    (pwm_p),
  .pwm_n    (pwm_n)
);

// File: tb/dither_pwm_bench.sv
module dither_pwm_bench;
  localparam int CW  = 5;
  localparam int SW  = 5;
  localparam int PER = 1 << CW;
  localparam int FRM = 1 << SW;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       kill_n;
  logic       pwm_p;
  logic       pwm_n;

  int unsigned cyc;
  int          checks;
  int          errors;
  int          hi_seen;
  bit          done;

  typedef struct {
    int unsigned cyc;
    bit          p;
    bit          n;
    string       req;
  } item_t;
  item_t sb_q[$];

  dither_pwm #(.CNT_W(CW), .STEP_W(SW)) u_dither_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .kill_n  (kill_n),
    .pwm_p   (pwm_p),
    .pwm_n   (pwm_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected items in their due cycle
  always @(negedge clk) begin
    item_t it;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      it = sb_q.pop_front();
      if (it.cyc < cyc) begin
        chk(1'b0, it.req, int'(cyc), int'(it.cyc));
      end else begin
        chk((pwm_p == it.p) && (pwm_n == it.n), it.req,
            int'({pwm_p, pwm_n}), int'({it.p, it.n}));
        if (pwm_p) hi_seen++;
      end
    end
  end

  function automatic bit exp_p(input int dc, input int st, input int per, input int c);
    int r;
    int pm;
    r  = 0;
    pm = per % FRM;
    for (int b = 0; b < SW; b++) begin
      if (((pm >> b) & 1) != 0) r = r | (1 << (SW - 1 - b));
    end
    return c < (dc + ((r < st) ? 1 : 0));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == exp[7:0], req, int'(rd_data), exp);
  endtask

  task automatic set_duty(input int dc, input int st);
    int w;
    w = dc * 32 + st;
    wr(2'd1, 8'(w >> 8));
    wr(2'd2, 8'(w & 255));
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic push_zero(input int n, input string req);
    for (int k = 0; k < n; k++) sb_q.push_back('{cyc + k, 1'b0, 1'b0, req});
  endtask

  // full frame starting from an enabling write
  task automatic run_frame(input int dc, input int st, input string req);
    int unsigned base;
    bit e;
    wr(2'd0, 8'h06);
    set_duty(dc, st);
    wr(2'd0, 8'h07);
    base = cyc;
    hi_seen = 0;
    for (int j = 0; j < PER * FRM; j++) begin
      e = exp_p(dc, st, j / PER, j % PER);
      sb_q.push_back('{base + j, e, !e, req});
    end
    drain();
    chk(hi_seen == FRM * dc + st, req, hi_seen, FRM * dc + st);
  endtask

  initial begin
    int unsigned base;
    int unsigned c0;
    int unsigned cl;
    int          w_new;
    bit          e;
    int          j;
    int          s;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; kill_n = 1'b1;
    checks = 0; errors = 0; hi_seen = 0; done = 1'b0; cyc = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    chk(!pwm_p && !pwm_n, "R1", int'({pwm_p, pwm_n}), 0);
    rd(2'd0, 0, "R1");
    rd(2'd1, 0, "R1");
    rd(2'd2, 0, "R1");

    // R3 / R2 held high byte, commit on low byte
    wr(2'd1, 8'h01);
    rd(2'd1, 0, "R3");
    rd(2'd2, 0, "R3");
    wr(2'd2, 8'h45);
    rd(2'd1, 8'h01, "R2");
    rd(2'd2, 8'h45, "R2");

    // R8 run enable off
    wr(2'd0, 8'h06);
    rd(2'd0, 8'h06, "R2");
    push_zero(40, "R8");
    drain();

    // R4 R5 R6 frame dc=10 step=5
    run_frame(10, 5, "R5");

    // R7 mid-period commit: 10/5 -> 20/31
    base = cyc;
    wr(2'd0, 8'h06);
    wr(2'd0, 8'h07);
    base = cyc;
    repeat (10) @(posedge clk);
    #1;
    c0 = cyc;
    cl = c0 + 4;
    for (int x = int'(c0) + 1; x <= int'(cl) + 95; x++) begin
      j = x - int'(base);
      s = int'(base) + (j / PER) * PER;
      if (s > int'(cl)) e = exp_p(20, 31, j / PER, j % PER);
      else              e = exp_p(10, 5, j / PER, j % PER);
      sb_q.push_back('{x, e, !e, "R7"});
    end
    w_new = 20 * 32 + 31;
    wr(2'd1, 8'(w_new >> 8));
    rd(2'd1, 8'h01, "R3");
    wr(2'd2, 8'(w_new & 255));
    drain();

    // R5 boundaries
    run_frame(31, 31, "R5");
    run_frame(0, 0, "R4");
    run_frame(0, 1, "R5");

    // R9 no drive, R10 frequency mode
    set_duty(12, 3);
    wr(2'd0, 8'h03);
    push_zero(40, "R9");
    drain();
    wr(2'd0, 8'h05);
    push_zero(40, "R10");
    drain();

    // R11 R12 kill honoured
    wr(2'd0, 8'h06);
    set_duty(16, 0);
    wr(2'd0, 8'h0F);
    #1 chk(pwm_p ^ pwm_n, "R6", int'({pwm_p, pwm_n}), 2);
    kill_n = 1'b0;
    #1 chk(!pwm_p && !pwm_n, "R11", int'({pwm_p, pwm_n}), 0);
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, 8'h0E, "R11");
    wr(2'd0, 8'h0F);
    rd(2'd0, 8'h0E, "R12");
    kill_n = 1'b1;
    #1 chk(!pwm_p && !pwm_n, "R12", int'({pwm_p, pwm_n}), 0);
    repeat (2) @(posedge clk);
    #1;
    wr(2'd0, 8'h0F);
    rd(2'd0, 8'h0F, "R12");
    chk(pwm_p ^ pwm_n, "R6", int'({pwm_p, pwm_n}), 2);

    // R13 kill not honoured
    wr(2'd0, 8'h07);
    kill_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    rd(2'd0, 8'h07, "R13");
    chk(pwm_p ^ pwm_n, "R13", int'({pwm_p, pwm_n}), 2);
    kill_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule